// File: doc/BRIEF.md
# SDRAM Controller with Periodic Refresh

This block sits between a simple single-word request port and one SDRAM device. Each accepted request is turned into a short command sequence. The row is opened, the row-to-column delay is waited out, and then one read or write command with auto-precharge is issued. The block then waits for the row to close before it accepts the next request. Read data is captured a fixed CAS latency after the read command and is returned with a one-cycle response pulse. There is no bursting, and only one row is open at any time.

After reset the controller runs a power-up sequence and only then accepts work. It also keeps a refresh interval counter. When that counter expires while the controller is idle, the controller closes all banks and issues an auto-refresh. The busy flag holds off any request that arrives during this. The held request is served as soon as the refresh completes.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is high, `mem_cke` is 0, `req_busy` is 1 and `rsp_valid` is 0. After reset is released, the first non-NOP command appears exactly INIT_CYCLES (100) cycles later. The power-up sequence is then, in this order: a precharge with `mem_a[10]`=1, two auto-refresh commands, and a load-mode command on bank 0 with `mem_a`=13'h020 (CAS latency 2 in bits 6:4, burst length 1 in bits 2:0).
- R2: The commands on {cs_n, ras_n, cas_n, we_n} are encoded as follows: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R3: The 23-bit request address is split into bank [22:21], row [20:8] and column [7:0]. ACTIVE drives the bank and the row. READ and WRITE drive the column on `mem_a[7:0]` with `mem_a[10]`=1 (auto-precharge).
- R4: A request is accepted on a clock edge where `req_valid`=1 and `req_busy`=0. `req_busy` is 1 from the next cycle onward. When no refresh is due, it falls 7 cycles after a write is accepted and 9 cycles after a read is accepted.
- R5: The READ or WRITE command follows its ACTIVE command exactly T_RCD (2) cycles later.
- R6: Read data is sampled from `mem_dq_in` CAS_LAT (2) cycles after the READ command. `rsp_valid` is high for exactly one cycle, 5 cycles after acceptance, and `rsp_rdata` carries the stored word at that time.
- R7: The WRITE command is issued with `mem_dq_out` equal to the accepted write data and with `mem_dqm`=0. `mem_dqm` is all ones outside an access, for example during refresh.
- R8: A refresh counter advances on every clock and saturates at REF_LIMIT (750). When it has expired and the controller is idle, a PRECHARGE is issued, followed T_RP (2) cycles later by an AUTO REFRESH. While no requests arrive, consecutive refresh commands are REF_LIMIT+1+T_RP (753) cycles apart.
- R9: Issuing an auto-refresh clears the counter. The refresh state of the controller's state machine is encoded as 7.
- R10: A request presented while a refresh is pending is held off by `req_busy`. Its ACTIVE command follows the refresh command by T_RFC+1 (5) cycles, and the request completes with correct data.
- R11: Writes produce no `rsp_valid` pulse. Each read produces exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address {bank, row, column} |
| req_wdata | input | 32 | Write data |
| req_busy | output | 1 | Request cannot be accepted this cycle |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 32 | Read data |
| mem_cke | output | 1 | Clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dqm | output | 4 | Byte masks |
| mem_ba | output | 2 | Bank address |
| mem_a | output | 13 | Row/column/mode address |
| mem_dq_in | input | 32 | Data from the memory |
| mem_dq_out | output | 32 | Data to the memory |

## Verification
A corrupted state or timer value reaches the command pins within one cycle. It shows as a misplaced command, a wrong ACTIVE-to-column gap, or a refresh without its preceding precharge. A mis-timed capture returns a garbage pattern, because the memory model drives valid data only in the single cycle the CAS latency selects. A refresh counter that is not cleared or that wraps shows up only at the next refresh, up to 753 cycles later, as a wrong refresh spacing. A busy flag that is cleared too early lets a request start during the refresh window, and this is caught by the exact ACTIVE-after-refresh spacing.

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl #(
  parameter int DW          = 32,
  parameter int BA_W        = 2,
  parameter int ROW_W       = 13,
  parameter int COL_W       = 8,
  parameter int AW          = BA_W + ROW_W + COL_W,
  parameter int CAS_LAT     = 2,
  parameter int T_RCD       = 2,
  parameter int T_RP        = 2,
  parameter int T_WR        = 2,
  parameter int T_RFC       = 4,
  parameter int T_MRD       = 2,
  parameter int INIT_CYCLES = 100,
  parameter int REF_LIMIT   = 750
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_busy,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             mem_cke,
  output logic             mem_cs_n,
  output logic             mem_ras_n,
  output logic             mem_cas_n,
  output logic             mem_we_n,
  output logic [DW/8-1:0]  mem_dqm,
  output logic [BA_W-1:0]  mem_ba,
  output logic [ROW_W-1:0] mem_a,
  input  logic [DW-1:0]    mem_dq_in,
  output logic [DW-1:0]    mem_dq_out
);

  localparam int TMAX  = (INIT_CYCLES > 64) ? INIT_CYCLES : 64;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int RCW   = $clog2(REF_LIMIT + 1);
  localparam int T_REC = T_WR + T_RP;
  localparam logic [ROW_W-1:0] AP_MASK   = ROW_W'(1) << 10;
  localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [3:0] {
    S_PWRUP = 4'd0, S_IPRE = 4'd1, S_IREF = 4'd2, S_LMR = 4'd3,
    S_IDLE  = 4'd4, S_ACT  = 4'd5, S_RW   = 4'd6, S_REF = 4'd7,
    S_PRE   = 4'd8, S_RECOV = 4'd9
  } st_t;

  st_t              state_q;
  logic [TW-1:0]    tmr_q;
  logic [RCW-1:0]   ref_cnt_q;
  logic             second_ref_q;
  logic [3:0]       cmd_q;
  logic [BA_W-1:0]  ba_q;
  logic [ROW_W-1:0] a_q;
  logic             cke_q;
  logic             wr_q;
  logic [COL_W-1:0] col_q;
  logic [DW-1:0]    wdata_q;
  logic [DW-1:0]    rdata_q;
  logic             rvalid_q;

  logic ref_due, tmr_done, in_access;

  assign ref_due   = ref_cnt_q >= RCW'(REF_LIMIT);
  assign tmr_done  = tmr_q == '0;
  assign in_access = (state_q == S_ACT) || (state_q == S_RW) || (state_q == S_RECOV);

  assign req_busy  = (state_q != S_IDLE) || ref_due;
  assign rsp_valid = rvalid_q;
  assign rsp_rdata = rdata_q;
  assign mem_cke   = cke_q;
  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
  assign mem_dqm    = in_access ? '0 : '1;
  assign mem_ba     = ba_q;
  assign mem_a      = a_q;
  assign mem_dq_out = wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_PWRUP;
      tmr_q        <= TW'(INIT_CYCLES - 1);
      ref_cnt_q    <= '0;
      second_ref_q <= 1'b0;
      cmd_q        <= C_NOP;
      ba_q         <= '0;
      a_q          <= '0;
      cke_q        <= 1'b0;
      wr_q         <= 1'b0;
      col_q        <= '0;
      wdata_q      <= '0;
      rdata_q      <= '0;
      rvalid_q     <= 1'b0;
    end else begin
      cke_q    <= 1'b1;
      cmd_q    <= C_NOP;
      rvalid_q <= 1'b0;
      if (!ref_due) ref_cnt_q <= ref_cnt_q + 1'b1;
      if (!tmr_done) tmr_q <= tmr_q - 1'b1;

      case (state_q)
        S_PWRUP: if (tmr_done) begin
          state_q <= S_IPRE;
          cmd_q   <= C_PRE;
          a_q     <= AP_MASK;
          tmr_q   <= TW'(T_RP - 1);
        end
        S_IPRE: if (tmr_done) begin
          state_q   <= S_IREF;
          cmd_q     <= C_REF;
          ref_cnt_q <= '0;
          tmr_q     <= TW'(T_RFC - 1);
        end
        S_IREF: if (tmr_done) begin
          if (!second_ref_q) begin
            second_ref_q <= 1'b1;
            cmd_q        <= C_REF;
            ref_cnt_q    <= '0;
            tmr_q        <= TW'(T_RFC - 1);
          end else begin
            state_q <= S_LMR;
            cmd_q   <= C_LMR;
            ba_q    <= '0;
            a_q     <= MODE_WORD;
            tmr_q   <= TW'(T_MRD - 1);
          end
        end
        S_LMR: if (tmr_done) state_q <= S_IDLE;
        S_IDLE: begin
          if (ref_due) begin
            state_q <= S_PRE;
            cmd_q   <= C_PRE;
            a_q     <= AP_MASK;
            tmr_q   <= TW'(T_RP - 1);
          end else if (req_valid) begin
            state_q <= S_ACT;
            cmd_q   <= C_ACT;
            wr_q    <= req_write;
            wdata_q <= req_wdata;
            col_q   <= req_addr[COL_W-1:0];
            ba_q    <= req_addr[AW-1 -: BA_W];
            a_q     <= req_addr[COL_W +: ROW_W];
            tmr_q   <= TW'(T_RCD - 1);
          end
        end
        S_ACT: if (tmr_done) begin
          state_q <= S_RW;
          cmd_q   <= wr_q ? C_WR : C_RD;
          a_q     <= ROW_W'(col_q) | AP_MASK;
          tmr_q   <= wr_q ? '0 : TW'(CAS_LAT);
        end
        S_RW: if (tmr_done) begin
          if (!wr_q) begin
            rdata_q  <= mem_dq_in;
            rvalid_q <= 1'b1;
          end
          state_q <= S_RECOV;
          tmr_q   <= TW'(T_REC - 1);
        end
        S_RECOV: if (tmr_done) state_q <= S_IDLE;
        S_PRE: if (tmr_done) begin
          state_q   <= S_REF;
          cmd_q     <= C_REF;
          ref_cnt_q <= '0;
          tmr_q     <= TW'(T_RFC - 1);
        end
        S_REF: if (tmr_done) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdram_seq_ctrl_chk.sv
module sdram_seq_ctrl_chk #(
  parameter int ROW_W = 13,
  parameter int MW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_busy,
  input logic             rsp_valid,
  input logic [3:0]       cmd,
  input logic [ROW_W-1:0] mem_a,
  input logic [MW-1:0]    mem_dqm,
  input logic [3:0]       state_q
);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_ACT = 4'b0011;
  localparam logic [3:0] C_RD  = 4'b0101;
  localparam logic [3:0] C_WR  = 4'b0100;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  logic [3:0] last_cmd;
  logic       lmr_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_cmd <= C_NOP;
      lmr_seen <= 1'b0;
    end else begin
      if (cmd != C_NOP) last_cmd <= cmd;
      if (cmd == C_LMR) lmr_seen <= 1'b1;
    end
  end

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_busy) |=> req_busy);

  assert_autoprecharge_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_RD || cmd == C_WR) |-> mem_a[10]);

  assert_act_before_column_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_RD || cmd == C_WR) |-> last_cmd == C_ACT);

  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_write_unmasked_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_WR) |-> mem_dqm == '0);

  assert_pre_before_ref_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_REF && lmr_seen) |-> last_cmd == C_PRE);

  assert_refresh_state_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_REF && lmr_seen) |-> state_q == 4'd7);

endmodule

bind sdram_seq_ctrl sdram_seq_ctrl_chk #(.ROW_W(ROW_W), .MW(DW/8)) chk_i (
  .clk(clk),
  .rst(rst),
  .req_valid(req_valid),
  .req_busy(req_busy),
  .rsp_valid(rsp_valid),
  .cmd({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}),
  .mem_a(mem_a),
  .mem_dqm(mem_dqm),
  .state_q(state_q)
);

// File: tb/sdram_seq_ctrl_tb_top.sv
module sdram_seq_ctrl_tb_top;
  localparam int CL = 2, TRCD = 2, TRP = 2, TWR = 2, TRFC = 4, TMRD = 2;
  localparam int INIT = 100, RLIM = 750;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;
  localparam logic [31:0] GARB = 32'hDEAD_BEEF;

  // {write, bank, row, column, data/expected}
  localparam int NV = 11;
  localparam logic [55:0] VEC [NV] = '{
    {1'b1, 2'd0, 13'd5,    8'd3,   32'h1111_0001},
    {1'b1, 2'd1, 13'd5,    8'd3,   32'h2222_0002},
    {1'b1, 2'd3, 13'd8191, 8'd255, 32'hA5A5_5A5A},
    {1'b1, 2'd0, 13'd0,    8'd0,   32'hFFFF_FFFF},
    {1'b0, 2'd0, 13'd5,    8'd3,   32'h1111_0001},
    {1'b0, 2'd1, 13'd5,    8'd3,   32'h2222_0002},
    {1'b1, 2'd0, 13'd5,    8'd3,   32'h3333_0003},
    {1'b0, 2'd3, 13'd8191, 8'd255, 32'hA5A5_5A5A},
    {1'b0, 2'd0, 13'd5,    8'd3,   32'h3333_0003},
    {1'b0, 2'd0, 13'd0,    8'd0,   32'hFFFF_FFFF},
    {1'b0, 2'd2, 13'd100,  8'd7,   {9'h1A5, 2'd2, 13'd100, 8'd7}}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_busy, rsp_valid, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [31:0] rsp_rdata, mem_dq_out;
  logic [31:0] mem_dq_in = GARB;
  logic [3:0] mem_dqm;
  logic [1:0] mem_ba;
  logic [12:0] mem_a;
  logic [3:0] cmd;
  assign cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

  sdram_seq_ctrl #(.CAS_LAT(CL), .T_RCD(TRCD), .T_RP(TRP), .T_WR(TWR), .T_RFC(TRFC),
                   .T_MRD(TMRD), .INIT_CYCLES(INIT), .REF_LIMIT(RLIM)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_busy(req_busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cke(mem_cke), .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_dqm(mem_dqm), .mem_ba(mem_ba), .mem_a(mem_a),
    .mem_dq_in(mem_dq_in), .mem_dq_out(mem_dq_out));

  int n_tests = 0, n_fail = 0, n_reads = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and command monitor
  logic [31:0] mem [logic [22:0]];
  logic [12:0] open_row [4];
  int cyc = 0, since_rst = 0, act_cyc = -100, ref_cyc = -100, prev_ref = -100, pre_cyc = -100;
  int n_init = 0, first_cyc = -1, pend = 0, n_rsp = 0;
  int err_ap = 0, err_rcd = 0, err_dqm = 0, err_refpre = 0, err_pulse = 0;
  logic [3:0] init_cmd [4];
  logic [12:0] init_a [4];
  logic [1:0] init_ba [4];
  logic [3:0] last_nn = C_NOP;
  logic [31:0] pdat = '0;
  bit lmr_seen = 1'b0, prev_rsp = 1'b0;

  function automatic logic [31:0] rd_mem(input logic [22:0] k);
    return mem.exists(k) ? mem[k] : {9'h1A5, k};
  endfunction

  always @(negedge clk) begin
    logic [22:0] key;
    cyc++;
    if (rst) since_rst = 0; else since_rst++;
    if (pend > 0) begin
      pend--;
      mem_dq_in = (pend == 0) ? pdat : GARB;
    end else mem_dq_in = GARB;
    if (!rst) begin
      if (rsp_valid) begin n_rsp++; if (prev_rsp) err_pulse++; end
      prev_rsp = rsp_valid;
      if (cmd != C_NOP) begin
        if (!lmr_seen && n_init < 4) begin
          init_cmd[n_init] = cmd; init_a[n_init] = mem_a; init_ba[n_init] = mem_ba;
          if (n_init == 0) first_cyc = since_rst;
          n_init++;
        end
        key = {mem_ba, open_row[mem_ba], mem_a[7:0]};
        case (cmd)
          C_ACT: begin open_row[mem_ba] = mem_a; act_cyc = cyc; end
          C_RD, C_WR: begin
            if (!mem_a[10]) err_ap++;
            if (cyc - act_cyc != TRCD) err_rcd++;
            if (cmd == C_WR) begin
              if (mem_dqm != 4'h0) err_dqm++;
              mem[key] = mem_dq_out;
            end else begin
              pend = CL; pdat = rd_mem(key);
            end
          end
          C_PRE: pre_cyc = cyc;
          C_REF: begin
            if (lmr_seen && (last_nn != C_PRE || cyc - pre_cyc != TRP)) err_refpre++;
            if (mem_dqm != 4'hF) err_dqm++;
            prev_ref = ref_cyc; ref_cyc = cyc;
          end
          C_LMR: lmr_seen = 1'b1;
          default: ;
        endcase
        last_nn = cmd;
      end
    end
  end

  task automatic do_req(input bit we, input logic [22:0] ad, input logic [31:0] d);
    int lat;
    bit seen;
    forever begin @(negedge clk); if (!req_busy) break; end
    req_valid = 1'b1; req_write = we; req_addr = ad; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (we) begin
      seen = 1'b0;
      for (int k = 1; k <= 7; k++) begin
        @(negedge clk);
        if (rsp_valid) seen = 1'b1;
        if (k == 6) chk(req_busy == 1'b1, "R4 busy held during write", req_busy, 1);
        if (k == 7) chk(req_busy == 1'b0, "R4 busy released 7 cycles after write", req_busy, 0);
      end
      chk(!seen, "R11 no response pulse for write", seen, 0);
    end else begin
      n_reads++;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 20);
      chk(lat == 5, "R6 read latency", lat, 5);
      chk(rsp_rdata == d, "R2 R3 R6 read data", rsp_rdata, d);
      for (int k = 6; k <= 9; k++) begin
        @(negedge clk);
        if (k == 8) chk(req_busy == 1'b1, "R4 busy held during read", req_busy, 1);
        if (k == 9) chk(req_busy == 1'b0, "R4 busy released 9 cycles after read", req_busy, 0);
      end
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    chk(mem_cke == 1'b0, "R1 cke low in reset", mem_cke, 0);
    chk(req_busy == 1'b1, "R1 busy in reset", req_busy, 1);
    chk(rsp_valid == 1'b0, "R1 no response in reset", rsp_valid, 0);
    chk(cmd == C_NOP, "R2 NOP in reset", cmd, C_NOP);
    #1 rst = 1'b0;

    w = 0;
    do begin @(negedge clk); w++; end while ((req_busy || !lmr_seen) && w < 400);
    chk(first_cyc == INIT, "R1 power-up wait length", first_cyc, INIT);
    chk(init_cmd[0] == C_PRE && init_a[0][10], "R1 init precharge-all", {init_cmd[0], init_a[0]}, {C_PRE, 13'h400});
    chk(init_cmd[1] == C_REF, "R1 init first refresh", init_cmd[1], C_REF);
    chk(init_cmd[2] == C_REF, "R1 init second refresh", init_cmd[2], C_REF);
    chk(init_cmd[3] == C_LMR, "R1 init load mode", init_cmd[3], C_LMR);
    chk(init_a[3] == 13'h020 && init_ba[3] == 2'd0, "R1 mode word", {init_ba[3], init_a[3]}, 15'h020);
    chk(mem_cke == 1'b1, "R1 cke high after init", mem_cke, 1);

    for (int i = 0; i < NV; i++)
      do_req(VEC[i][55], VEC[i][54:32], VEC[i][31:0]);

    repeat (1700) @(negedge clk);
    chk(ref_cyc - prev_ref == RLIM + 1 + TRP, "R8 R9 idle refresh interval", ref_cyc - prev_ref, RLIM + 1 + TRP);

    forever begin @(negedge clk); if (cmd == C_PRE) break; end
    chk(req_busy == 1'b1, "R10 busy during refresh entry", req_busy, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {2'd1, 13'd5, 8'd3}; req_wdata = '0;
    forever begin if (!req_busy) break; @(negedge clk); end
    @(negedge clk);
    req_valid = 1'b0;
    n_reads++;
    w = 0;
    do begin @(negedge clk); w++; end while (!rsp_valid && w < 20);
    chk(w == 5 && rsp_rdata == 32'h2222_0002, "R10 held read served after refresh", rsp_rdata, 32'h2222_0002);
    chk(act_cyc - ref_cyc == TRFC + 1, "R10 activate follows refresh", act_cyc - ref_cyc, TRFC + 1);
    repeat (12) @(negedge clk);

    chk(err_ap == 0, "R3 auto-precharge bit on column commands", err_ap, 0);
    chk(err_rcd == 0, "R5 activate-to-column spacing", err_rcd, 0);
    chk(err_dqm == 0, "R7 data mask levels", err_dqm, 0);
    chk(err_refpre == 0, "R8 precharge precedes refresh", err_refpre, 0);
    chk(err_pulse == 0, "R6 single-cycle response", err_pulse, 0);
    chk(n_rsp == n_reads, "R11 one response per read", n_rsp, n_reads);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule